// File: doc/BRIEF.md
# DRAM Output Path Controller

This block models, one clock at a time, the output side of an asynchronous DRAM. It watches the four active-low strobes: row strobe, column strobe, write enable and output enable. From their relative ordering it decides three things. The first is whether the internal I/O path is open. The second is when the value on the data pins is captured into an output latch. The third is when the pins float. The storage array is not modelled: the value read from the addressed cell arrives on a plain `rd_data` input. A small code on `cycle_type` names the kind of memory cycle in progress.

A fast system clock samples the strobes through an optional synchronizer chain of `SYNC_STAGES` flops. Edges are found by comparing each synchronized strobe with its value one clock earlier. The data pins are given as a registered value `dq_out` plus a driver-enable flag `dq_oe`. The surrounding pad logic turns these into a tri-state bus.

Two cycles carry data across row-strobe boundaries. If the drivers are on when the row strobe rises, the data stays on the pins for as long as the column strobe stays low. The same happens when a refresh begins while the column strobe is already low.

Top module: `dram_out_ctl`

## Requirements
- R1: While reset is asserted, `dq_out` is zero, `dq_oe` is 0 and `cycle_type` is 0 (idle).
- R2: Row strobe falls, then the column strobe falls with write enable high. The cycle reads as code 1. With output enable low, `dq_oe` rises and `dq_out` carries `rd_data`. Each result appears SYNC_STAGES+1 clocks after the strobe change.
- R3: Output enable high turns `dq_oe` off.
- R4: Output enable high leaves `dq_out` unchanged even when `rd_data` changes.
- R5: Column strobe high turns `dq_oe` off. A column-strobe fall while the row strobe is high sets code 7 and enables no drivers.
- R6: Write enable already low when the column strobe falls marks an early write, code 2. The pins stay floating until the column strobe rises, even if write enable returns high.
- R7: Write enable falling during a read with the column strobe low turns the drivers off. The cycle becomes code 4 (read-modify-write) if data was being driven, otherwise code 3 (late write).
- R8: Row strobe falling with the column strobe high gives code 5 (row-only refresh). The pins float.
- R9: When the row strobe rises while `dq_oe` is 1, the value in `dq_out` is held. It stays driven while the column strobe is low, output enable is low and write enable is high. Raising the column strobe ends the hold. While the row strobe is high, `dq_out` never takes new data.
- R10: Row strobe falling while the column strobe is low gives code 6 (refresh with the column strobe first). `dq_out` and `dq_oe` keep what the previous cycle left on them, and no new data is captured.
- R11: Each further column-strobe fall under the same low row strobe classifies the cycle again and captures fresh `rd_data` (page mode).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| rd_data | input | DATA_W | Data from the addressed cell |
| dq_out | output | DATA_W | Output latch value presented to the pins |
| dq_oe | output | 1 | Pin driver enable (0 = high-Z) |
| cycle_type | output | 3 | Cycle code: 0 idle, 1 read, 2 early write, 3 late write, 4 read-modify-write, 5 row-only refresh, 6 column-first refresh, 7 column-only |

## Verification
Every result is due SYNC_STAGES+1 clocks after its strobe change. The synchronizer takes SYNC_STAGES flops, and the classifier and the latch register together in one further stage. The vector walk holds each strobe pattern for six clocks and samples on a falling edge at the end of that hold. By then every result has settled, yet the next edge has not happened. A directed test counts edges precisely: it checks that `dq_oe` is still low one sample before the due clock and high on it.

// File: rtl/dram_oc_pkg.sv
package dram_oc_pkg;

   typedef enum logic [2:0] {
      CYC_IDLE     = 3'd0,
      CYC_READ     = 3'd1,
      CYC_EARLY_WR = 3'd2,
      CYC_LATE_WR  = 3'd3,
      CYC_RMW      = 3'd4,
      CYC_RAS_ONLY = 3'd5,
      CYC_CBR      = 3'd6,
      CYC_CAS_ONLY = 3'd7
   } cyc_e;

   localparam int STROBE_W = 4;

endpackage

// File: rtl/dram_strobe_sync.sv
module dram_strobe_sync #(
   parameter int              WIDTH   = 4,
   parameter int              STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   if (STAGES == 0) begin : g_bypass
      assign q_o = d_i;
   end else begin : g_chain
      logic [WIDTH-1:0] stg [STAGES];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) stg[k] <= RST_VAL;
         end else begin
            stg[0] <= d_i;
            for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
         end
      end

      assign q_o = stg[STAGES-1];
   end

endmodule

// File: rtl/dram_cycle_classify.sv
module dram_cycle_classify
   import dram_oc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ras_n_i,
   input  logic       cas_n_i,
   input  logic       we_n_i,
   input  logic       drv_i,
   output logic       ras_rise_o,
   output logic       live_path_o,
   output cyc_e       type_o
);

   logic ras_q, cas_q, we_q, ewr_q, ewr_d;
   logic ras_fall, cas_fall, we_fall;
   cyc_e type_q, type_d;

   assign ras_fall   = ras_q & ~ras_n_i;
   assign ras_rise_o = ~ras_q & ras_n_i;
   assign cas_fall   = cas_q & ~cas_n_i;
   assign we_fall    = we_q & ~we_n_i;

   always_comb begin
      type_d = type_q;
      if (ras_fall)
         type_d = cas_n_i ? CYC_RAS_ONLY : CYC_CBR;
      else if (!ras_n_i && type_q != CYC_CBR && cas_fall)
         type_d = we_n_i ? CYC_READ : CYC_EARLY_WR;
      else if (!ras_n_i && type_q == CYC_READ && we_fall && !cas_n_i)
         type_d = drv_i ? CYC_RMW : CYC_LATE_WR;
      else if (ras_n_i && cas_fall)
         type_d = CYC_CAS_ONLY;
   end

   always_comb begin
      if (cas_n_i)
         ewr_d = 1'b0;
      else if (!ras_n_i && cas_fall && !we_n_i)
         ewr_d = 1'b1;
      else
         ewr_d = ewr_q;
   end

   assign live_path_o = ~ras_n_i & ~cas_n_i & (type_d != CYC_CBR) & ~ewr_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ras_q  <= 1'b1;
         cas_q  <= 1'b1;
         we_q   <= 1'b1;
         ewr_q  <= 1'b0;
         type_q <= CYC_IDLE;
      end else begin
         ras_q  <= ras_n_i;
         cas_q  <= cas_n_i;
         we_q   <= we_n_i;
         ewr_q  <= ewr_d;
         type_q <= type_d;
      end
   end

   assign type_o = type_q;

endmodule

// File: rtl/dram_out_latch.sv
module dram_out_latch #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              live_path_i,
   input  logic              ras_rise_i,
   input  logic              cas_n_i,
   input  logic              we_n_i,
   input  logic              oe_n_i,
   input  logic [DATA_W-1:0] data_i,
   output logic [DATA_W-1:0] dq_o,
   output logic              oe_o
);

   logic              held_q, held_d, drive_d, capture;
   logic [DATA_W-1:0] dq_q;
   logic              oe_q;

   always_comb begin
      if (cas_n_i)
         held_d = 1'b0;
      else if (ras_rise_i && oe_q)
         held_d = 1'b1;
      else
         held_d = held_q;
   end

   assign capture = live_path_i & ~oe_n_i & we_n_i;
   assign drive_d = (live_path_i | held_d) & ~oe_n_i & we_n_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_q <= 1'b0;
         oe_q   <= 1'b0;
         dq_q   <= '0;
      end else begin
         held_q <= held_d;
         oe_q   <= drive_d;
         if (capture) dq_q <= data_i;
      end
   end

   assign dq_o = dq_q;
   assign oe_o = oe_q;

endmodule

// File: rtl/dram_out_ctl.sv
module dram_out_ctl
   import dram_oc_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ras_n,
   input  logic              cas_n,
   input  logic              we_n,
   input  logic              oe_n,
   input  logic [DATA_W-1:0] rd_data,
   output logic [DATA_W-1:0] dq_out,
   output logic              dq_oe,
   output logic [2:0]        cycle_type
);

   localparam int LATENCY = SYNC_STAGES + 1;

   if (DATA_W < 1) begin : g_bad_width
      $error("dram_out_ctl: DATA_W must be at least 1");
   end
   if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("dram_out_ctl: SYNC_STAGES must lie in 0..4");
   end
   if (LATENCY < 1) begin : g_bad_lat
      $error("dram_out_ctl: derived latency invalid");
   end

   logic [STROBE_W-1:0] strb_s;
   logic [DATA_W-1:0]   data_s;
   logic                ras_s, cas_s, we_s, oe_s;
   logic                ras_rise, live_path;
   cyc_e                cyc;

   dram_strobe_sync #(.WIDTH(STROBE_W), .STAGES(SYNC_STAGES), .RST_VAL({STROBE_W{1'b1}}))
      i_strb_sync (.clk(clk), .rst_n(rst_n), .d_i({ras_n, cas_n, we_n, oe_n}), .q_o(strb_s));

   dram_strobe_sync #(.WIDTH(DATA_W), .STAGES(SYNC_STAGES), .RST_VAL('0))
      i_data_sync (.clk(clk), .rst_n(rst_n), .d_i(rd_data), .q_o(data_s));

   assign {ras_s, cas_s, we_s, oe_s} = strb_s;

   dram_cycle_classify i_classify (
      .clk        (clk),
      .rst_n      (rst_n),
      .ras_n_i    (ras_s),
      .cas_n_i    (cas_s),
      .we_n_i     (we_s),
      .drv_i      (dq_oe),
      .ras_rise_o (ras_rise),
      .live_path_o(live_path),
      .type_o     (cyc)
   );

   dram_out_latch #(.DATA_W(DATA_W)) i_latch (
      .clk        (clk),
      .rst_n      (rst_n),
      .live_path_i(live_path),
      .ras_rise_i (ras_rise),
      .cas_n_i    (cas_s),
      .we_n_i     (we_s),
      .oe_n_i     (oe_s),
      .data_i     (data_s),
      .dq_o       (dq_out),
      .oe_o       (dq_oe)
   );

   assign cycle_type = cyc;

endmodule

// File: rtl/dram_out_ctl_chk.sv
module dram_out_ctl_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ras_s,
   input logic              cas_s,
   input logic              we_s,
   input logic              oe_s,
   input logic [DATA_W-1:0] dq_out,
   input logic              dq_oe,
   input logic [2:0]        cycle_type
);

   a_r3_oe_high_floats: assert property (@(posedge clk) disable iff (!rst_n)
      oe_s |=> !dq_oe);

   a_r4_oe_keeps_latch: assert property (@(posedge clk) disable iff (!rst_n)
      oe_s |=> $stable(dq_out));

   a_r5_cas_high_floats: assert property (@(posedge clk) disable iff (!rst_n)
      cas_s |=> !dq_oe);

   a_r7_we_low_floats: assert property (@(posedge clk) disable iff (!rst_n)
      !we_s |=> !dq_oe);

   a_r9_ras_high_no_capture: assert property (@(posedge clk) disable iff (!rst_n)
      ras_s |=> $stable(dq_out));

   a_r10_cbr_detect: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(ras_s) && !cas_s) |=> (cycle_type == 3'd6));

   a_r8_ras_only_detect: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(ras_s) && cas_s) |=> (cycle_type == 3'd5 && !dq_oe));

endmodule

bind dram_out_ctl dram_out_ctl_chk #(.DATA_W(DATA_W)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ras_s     (ras_s),
   .cas_s     (cas_s),
   .we_s      (we_s),
   .oe_s      (oe_s),
   .dq_out    (dq_out),
   .dq_oe     (dq_oe),
   .cycle_type(cycle_type)
);

// File: tb/test_dram_out_ctl.sv
`timescale 1ns/1ps
module test_dram_out_ctl;

   localparam int DATA_W = 8;
   localparam int SYNC   = 2;
   localparam int HOLD   = 6;
   localparam int NVEC   = 26;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b0;
   logic [DATA_W-1:0] rd_data = '0;
   logic [DATA_W-1:0] dq_out;
   logic              dq_oe;
   logic [2:0]        cycle_type;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   dram_out_ctl #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC)) i_dram_out_ctl (
      .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
      .oe_n(oe_n), .rd_data(rd_data), .dq_out(dq_out), .dq_oe(dq_oe),
      .cycle_type(cycle_type)
   );

   // {ras,cas,we,oe}, rd_data, exp_oe, exp_dq, exp_type, requirement
   localparam logic [31:0] VEC [NVEC] = '{
      {4'b1110, 8'h11, 1'b0, 8'h00, 3'd0, 8'd1 },  // R1 idle after reset
      {4'b0110, 8'h11, 1'b0, 8'h00, 3'd5, 8'd8 },  // R8 row-only
      {4'b0010, 8'hA5, 1'b1, 8'hA5, 3'd1, 8'd2 },  // R2 read
      {4'b0011, 8'h3C, 1'b0, 8'hA5, 3'd1, 8'd4 },  // R3 R4 oe high
      {4'b0010, 8'h3C, 1'b1, 8'h3C, 3'd1, 8'd2 },  // R2 oe low again
      {4'b0110, 8'h3C, 1'b0, 8'h3C, 3'd1, 8'd5 },  // R5 cas high
      {4'b0010, 8'h5A, 1'b1, 8'h5A, 3'd1, 8'd11},  // R11 page read
      {4'b0000, 8'h5A, 1'b0, 8'h5A, 3'd4, 8'd7 },  // R7 rmw
      {4'b0110, 8'h77, 1'b0, 8'h5A, 3'd4, 8'd5 },  // R5
      {4'b0000, 8'h77, 1'b0, 8'h5A, 3'd2, 8'd6 },  // R6 early write
      {4'b0010, 8'h77, 1'b0, 8'h5A, 3'd2, 8'd6 },  // R6 we back high
      {4'b0111, 8'h77, 1'b0, 8'h5A, 3'd2, 8'd5 },  // R5
      {4'b0011, 8'h66, 1'b0, 8'h5A, 3'd1, 8'd4 },  // R4 read, oe high
      {4'b0001, 8'h66, 1'b0, 8'h5A, 3'd3, 8'd7 },  // R7 late write
      {4'b1110, 8'h66, 1'b0, 8'h5A, 3'd3, 8'd9 },  // R9
      {4'b1010, 8'h99, 1'b0, 8'h5A, 3'd7, 8'd5 },  // R5 cas-only
      {4'b1110, 8'h99, 1'b0, 8'h5A, 3'd7, 8'd5 },  // R5
      {4'b0110, 8'hC3, 1'b0, 8'h5A, 3'd5, 8'd8 },  // R8
      {4'b0010, 8'hC3, 1'b1, 8'hC3, 3'd1, 8'd2 },  // R2
      {4'b1010, 8'h12, 1'b1, 8'hC3, 3'd1, 8'd9 },  // R9 held after ras rise
      {4'b0010, 8'h34, 1'b1, 8'hC3, 3'd6, 8'd10},  // R10 hidden refresh
      {4'b1010, 8'h34, 1'b1, 8'hC3, 3'd6, 8'd10},  // R10
      {4'b1110, 8'h34, 1'b0, 8'hC3, 3'd6, 8'd9 },  // R9 hold ends
      {4'b1010, 8'h55, 1'b0, 8'hC3, 3'd7, 8'd5 },  // R5
      {4'b0010, 8'h55, 1'b0, 8'hC3, 3'd6, 8'd10},  // R10 no drive
      {4'b1110, 8'h55, 1'b0, 8'hC3, 3'd6, 8'd10}   // R10
   };

   task automatic check(input int req, input string what, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL R%0d %s actual %0h expected %0h", req, what, got, exp);
      end
   endtask

   task automatic apply(input logic [31:0] v);
      {ras_n, cas_n, we_n, oe_n} = v[31:28];
      rd_data = v[27:20];
   endtask

   initial begin
      #(5.0 * 100000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired actual running expected finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check(1, "dq_oe in reset", {31'd0, dq_oe}, 32'd0);
      check(1, "dq_out in reset", {24'd0, dq_out}, 32'd0);
      check(1, "type in reset", {29'd0, cycle_type}, 32'd0);
      rst_n = 1'b1;

      for (int i = 0; i < NVEC; i++) begin
         @(negedge clk);
         apply(VEC[i]);
         repeat (HOLD) @(negedge clk);
         check(int'(VEC[i][7:0]), $sformatf("vec %0d dq_oe", i), {31'd0, dq_oe}, {31'd0, VEC[i][19]});
         check(int'(VEC[i][7:0]), $sformatf("vec %0d dq_out", i), {24'd0, dq_out}, {24'd0, VEC[i][18:11]});
         check(int'(VEC[i][7:0]), $sformatf("vec %0d type", i), {29'd0, cycle_type}, {29'd0, VEC[i][10:8]});
      end

      // R2 latency: output due exactly SYNC+1 clocks after the column strobe falls
      apply({4'b0110, 8'hE7, 20'd0});
      repeat (HOLD) @(negedge clk);
      cas_n = 1'b0;
      rd_data = 8'hE7;
      repeat (SYNC) @(negedge clk);
      check(2, "dq_oe one clock early", {31'd0, dq_oe}, 32'd0);
      @(negedge clk);
      check(2, "dq_oe on due clock", {31'd0, dq_oe}, 32'd1);
      check(2, "dq_out on due clock", {24'd0, dq_out}, 32'hE7);

      // R4 rd_data changing under oe high does not reach dq_out
      oe_n = 1'b1;
      repeat (HOLD) @(negedge clk);
      rd_data = 8'h0F;
      repeat (HOLD) @(negedge clk);
      check(4, "dq_out with oe high", {24'd0, dq_out}, 32'hE7);

      // R1 reset in mid-read clears everything
      oe_n = 1'b0;
      repeat (HOLD) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check(1, "dq_oe after reset", {31'd0, dq_oe}, 32'd0);
      check(1, "dq_out after reset", {24'd0, dq_out}, 32'd0);
      check(1, "type after reset", {29'd0, cycle_type}, 32'd0);
      apply({4'b1110, 8'h00, 20'd0});
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      repeat (HOLD) @(negedge clk);
      check(1, "idle after release", {31'd0, dq_oe}, 32'd0);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule